// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block runs on the host side of a parallel flash bus. Once software has finished the command sequence for a byte program or an erase, it pulses `start_i`. The block then reads the target location over and over until the in-band status bits in the returned byte show that the internal operation has finished. Two detection methods are available. In data-polling mode the block checks the top data bit against the value it expects at completion. In toggle mode it checks whether the next-to-top bit stayed the same across two consecutive reads.

The flash finishes its internal operation at a time that has no fixed relation to the host's reads. A single read can therefore catch the device in the middle of that change and look complete when it is not. To reject such reads, every read that looks complete must be followed by two more reads that also look complete before the block reports success.

A read-count limit ends a run that never completes. After a program, the block also compares the last byte it read against the intended byte and reports any difference.

Top module: `eps_poller`

## Requirements
- R1: A pulse on `start_i` while idle captures `addr_i`, `erase_i`, `toggle_i`, `exp_data_i` and `limit_i`, and raises `busy_o`. While busy, `rd_req_o` stays high and `rd_addr_o` holds the captured address. Each cycle in which `rd_ack_i` is high ends one read, and `rd_data_i` is sampled in that same cycle.
- R2: In data-polling mode (`toggle_i`=0) for a program (`erase_i`=0), a read looks complete when its bit 7 equals bit 7 of the expected byte.
- R3: In data-polling mode for an erase (`erase_i`=1), a read looks complete when its bit 7 is 1.
- R4: In toggle mode (`toggle_i`=1), a read looks complete when its bit 6 equals bit 6 of the previous read of the same run. The first read of a run never looks complete.
- R5: Completion is declared only on the third consecutive read that looks complete. A read that does not look complete cancels any pending confirmation, and polling continues.
- R6: `done_o` pulses for one cycle, in the cycle after the acknowledge of the final read. `busy_o` and `rd_req_o` are low from that cycle on.
- R7: For a program, `err_mismatch_o` pulses together with `done_o` when any bit of the final read differs from the expected byte. For an erase it never pulses.
- R8: With `limit_i` nonzero, if the run has made `limit_i` reads without declaring completion, `err_timeout_o` pulses (timing like R6) and the block returns to idle. When completion is declared on the read that reaches the limit, completion wins. A limit of 0 disables the timeout.
- R9: `start_i` is ignored while busy: the captured settings, and therefore the run's outcome, do not change.
- R10: After reset, `busy_o`, `rd_req_o`, `done_o`, `err_timeout_o` and `err_mismatch_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (ignored while busy) |
| erase_i | input | 1 | 1 = erase completion, 0 = program completion |
| toggle_i | input | 1 | 1 = toggle-bit method, 0 = data-polling method |
| addr_i | input | AW | Location to poll |
| exp_data_i | input | DW | Byte that was programmed |
| limit_i | input | LW | Read-count limit, 0 = no limit |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | DW | Read response data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Completion pulse |
| err_timeout_o | output | 1 | Limit reached without completion |
| err_mismatch_o | output | 1 | Programmed byte differs from expected |

## Verification
Some properties are checked on every cycle. Completion and timeout never pulse together. A mismatch only accompanies completion. Completion follows an acknowledge and leaves the block idle with no request. Every end of a run carries an outcome, and the read address is constant within a run. Other behaviour can only be shown by the bench's scenarios, because it depends on the flash's response history:

- how many reads each method and mode needs;
- that a read which falsely looks complete is rejected;
- that completion wins over the limit;
- that a second start during a run has no effect.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef enum logic {
    EPS_IDLE = 1'b0,
    EPS_READ = 1'b1
  } eps_state_e;
endpackage

// File: rtl/eps_status_eval.sv
// Decides whether one returned byte looks like a finished operation.
module eps_status_eval #(
  parameter int DW = 8
) (
  input  logic          toggle_i,
  input  logic          erase_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] data_i,
  input  logic          prev_vld_i,
  input  logic          prev_tog_i,
  output logic          ok_o
);
  localparam int PollBit = DW - 1;
  localparam int TogBit  = DW - 2;

  logic poll_ref;

  always_comb begin
    poll_ref = erase_i ? 1'b1 : exp_i[PollBit];
    if (toggle_i) ok_o = prev_vld_i && (data_i[TogBit] == prev_tog_i);
    else          ok_o = (data_i[PollBit] == poll_ref);
  end
endmodule

// File: rtl/eps_confirm.sv
// Counts consecutive complete-looking reads; hit on the last confirmation.
module eps_confirm #(
  parameter int NCONF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic ok_i,
  output logic hit_o
);
  localparam int CW = $clog2(NCONF + 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = step_i && ok_i && (cnt_q == CW'(NCONF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (!ok_i || hit_o) cnt_q <= '0;
      else                cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/eps_read_limit.sv
// Read counter with expiry against a programmable limit (0 = off).
module eps_read_limit #(
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [LW-1:0] limit_i,
  output logic          expire_o
);
  logic [LW:0] cnt_q;
  logic [LW:0] cnt_nx;

  assign cnt_nx   = cnt_q + (LW+1)'(1);
  assign expire_o = step_i && (|limit_i) && (cnt_nx >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/eps_poller.sv
module eps_poller
  import eps_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int LW    = 16,
  parameter int NCONF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic          toggle_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [LW-1:0] limit_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_timeout_o,
  output logic          err_mismatch_o
);
  localparam int TogBit = DW - 2;

  eps_state_e    state_q;
  logic          erase_q, toggle_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [LW-1:0] limit_q;
  logic          prev_vld_q, prev_tog_q;
  logic          done_q, to_q, mm_q;

  logic accept, ack, ok, hit, expire, fin_ok, fin_to;

  assign accept = start_i && (state_q == EPS_IDLE);
  assign ack    = rd_ack_i && (state_q == EPS_READ);
  assign fin_ok = hit;
  assign fin_to = expire && !hit;

  eps_status_eval #(.DW(DW)) i_eval (
    .toggle_i   (toggle_q),
    .erase_i    (erase_q),
    .exp_i      (exp_q),
    .data_i     (rd_data_i),
    .prev_vld_i (prev_vld_q),
    .prev_tog_i (prev_tog_q),
    .ok_o       (ok)
  );

  eps_confirm #(.NCONF(NCONF)) i_confirm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .step_i  (ack),
    .ok_i    (ok),
    .hit_o   (hit)
  );

  eps_read_limit #(.LW(LW)) i_limit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .step_i   (ack),
    .limit_i  (limit_q),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= EPS_IDLE;
      erase_q    <= 1'b0;
      toggle_q   <= 1'b0;
      addr_q     <= '0;
      exp_q      <= '0;
      limit_q    <= '0;
      prev_vld_q <= 1'b0;
      prev_tog_q <= 1'b0;
      done_q     <= 1'b0;
      to_q       <= 1'b0;
      mm_q       <= 1'b0;
    end else begin
      done_q <= fin_ok;
      to_q   <= fin_to;
      mm_q   <= fin_ok && !erase_q && (rd_data_i != exp_q);
      if (accept) begin
        state_q    <= EPS_READ;
        erase_q    <= erase_i;
        toggle_q   <= toggle_i;
        addr_q     <= addr_i;
        exp_q      <= exp_data_i;
        limit_q    <= limit_i;
        prev_vld_q <= 1'b0;
      end else if (ack) begin
        prev_vld_q <= 1'b1;
        prev_tog_q <= rd_data_i[TogBit];
        if (fin_ok || fin_to) state_q <= EPS_IDLE;
      end
    end
  end

  assign rd_req_o       = (state_q == EPS_READ);
  assign rd_addr_o      = addr_q;
  assign busy_o         = (state_q != EPS_IDLE);
  assign done_o         = done_q;
  assign err_timeout_o  = to_q;
  assign err_mismatch_o = mm_q;
endmodule

// File: rtl/eps_checker.sv
module eps_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic [DW-1:0] rd_data_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_timeout_o,
  input logic          err_mismatch_o
);
  a_r1_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

  a_r6_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_ack_i));

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !rd_req_o));

  a_r7_mismatch_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_mismatch_o |-> done_o);

  a_r8_outcome_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_timeout_o));

  a_r8_end_has_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_timeout_o));
endmodule

bind eps_poller eps_checker #(.AW(AW), .DW(DW)) i_eps_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_req_o       (rd_req_o),
  .rd_addr_o      (rd_addr_o),
  .rd_ack_i       (rd_ack_i),
  .rd_data_i      (rd_data_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_timeout_o  (err_timeout_o),
  .err_mismatch_o (err_mismatch_o)
);

// File: tb/test_eps_poller.sv
module test_eps_poller;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic        erase;
    logic        tog;
    logic [7:0]  exp;
    logic [7:0]  tru;
    logic [7:0]  bsy;
    logic [7:0]  glt;
    logic [15:0] lim;
    logic [7:0]  reads;
    logic        done;
    logic        to;
    logic        mm;
  } vec_t;

  // erase tog exp tru busy glitch limit reads done to mm
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'hA5, 8'hA5, 8'd4,  8'd0, 16'd0, 8'd7, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h3C, 8'h3C, 8'd0,  8'd0, 16'd0, 8'd3, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'hA5, 8'hA4, 8'd2,  8'd0, 16'd0, 8'd5, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'h00, 8'hFF, 8'd6,  8'd0, 16'd0, 8'd9, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h5A, 8'h5A, 8'd5,  8'd0, 16'd0, 8'd9, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h1A, 8'h1A, 8'd5,  8'd0, 16'd0, 8'd8, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 8'h00, 8'hFF, 8'd4,  8'd0, 16'd0, 8'd7, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h40, 8'h40, 8'd0,  8'd0, 16'd0, 8'd4, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h80, 8'h80, 8'd5,  8'd2, 16'd0, 8'd8, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'hA5, 8'hA5, 8'd20, 8'd0, 16'd6, 8'd6, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 8'h3C, 8'h3C, 8'd0,  8'd0, 16'd3, 8'd3, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h3C, 8'h3C, 8'd0,  8'd0, 16'd2, 8'd2, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 8'h12, 8'h12, 8'd1,  8'd0, 16'd0, 8'd4, 1'b1, 1'b0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, erase_i = 1'b0, toggle_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  exp_data_i = '0;
  logic [15:0] limit_i = '0;
  logic        rd_req_o;
  logic [15:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic        busy_o, done_o, err_timeout_o, err_mismatch_o;

  int checks = 0, failures = 0, cyc = 0;
  int rd_cnt = 0, addr_bad = 0;
  logic       m_erase = 1'b0;
  logic [7:0] m_true = '0;
  int         m_busy = 0, m_glt = 0;
  logic [15:0] m_addr = '0;

  eps_poller i_eps_poller (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] flash_byte(int k);
    logic t;
    t = logic'((k - 1) & 1);
    if (k <= m_busy && k != m_glt)
      return m_erase ? {1'b0, t, 6'b0} : {~m_true[7], t, m_true[5:0]};
    return m_true;
  endfunction

  // Flash responder: one acknowledge every other cycle while requested
  always @(negedge clk_i) begin
    if (!rst_ni) rd_ack_i = 1'b0;
    else if (rd_req_o && !rd_ack_i) begin
      rd_data_i = flash_byte(rd_cnt + 1);
      rd_ack_i  = 1'b1;
      rd_cnt    = rd_cnt + 1;
      if (rd_addr_o != m_addr) addr_bad = addr_bad + 1;
    end else rd_ack_i = 1'b0;
  end

  task automatic check(string tag, string what, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string row_tag(vec_t v);
    if (v.lim != 0) return "R8";
    if (v.glt != 0) return "R5";
    if (v.mm)       return "R7";
    if (v.tog)      return "R4";
    if (v.erase)    return "R3";
    return "R2";
  endfunction

  // Runs one poll; optional second start mid-run (R9)
  task automatic run(vec_t v, logic [15:0] adr, bit restart,
                     output int o_done, output int o_to, output int o_mm);
    m_erase = v.erase; m_true = v.tru; m_busy = int'(v.bsy);
    m_glt = int'(v.glt); m_addr = adr;
    @(negedge clk_i);
    rd_cnt = 0; addr_bad = 0;
    start_i = 1'b1; erase_i = v.erase; toggle_i = v.tog;
    exp_data_i = v.exp; limit_i = v.lim; addr_i = adr;
    @(negedge clk_i);
    start_i = 1'b0;
    o_done = 0; o_to = 0; o_mm = 0;
    for (int c = 0; c < 4000; c++) begin
      if (restart && c == 3) begin
        start_i = 1'b1; erase_i = 1'b1; toggle_i = 1'b1;
        exp_data_i = 8'h00; limit_i = 16'd1; addr_i = ~adr;
      end else if (restart && c == 4) start_i = 1'b0;
      if (done_o || err_timeout_o) begin
        o_done = int'(done_o); o_to = int'(err_timeout_o); o_mm = int'(err_mismatch_o);
        break;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  initial begin
    int d, t, m;
    repeat (3) @(negedge clk_i);
    check("R10", "busy", int'(busy_o), 0);
    check("R10", "req", int'(rd_req_o), 0);
    check("R10", "done", int'(done_o), 0);
    check("R10", "errors", int'(err_timeout_o | err_mismatch_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VECS[i], 16'h1000 + 16'(i), 1'b0, d, t, m);
      check(row_tag(VECS[i]), "done", d, int'(VECS[i].done));
      check("R8", "timeout", t, int'(VECS[i].to));
      check("R7", "mismatch", m, int'(VECS[i].mm));
      check(row_tag(VECS[i]), "reads", rd_cnt, int'(VECS[i].reads));
      check("R1", "read address", addr_bad, 0);
      @(negedge clk_i);
      check("R6", "idle after end", int'(busy_o | rd_req_o | done_o), 0);
    end

    // R9: a second start during the run changes nothing
    run(VECS[0], 16'h2468, 1'b1, d, t, m);
    check("R9", "done", d, 1);
    check("R9", "timeout", t, 0);
    check("R9", "mismatch", m, 0);
    check("R9", "reads", rd_cnt, 7);
    check("R9", "read address", addr_bad, 0);

    // R10: reset in the middle of a run
    m_busy = 50; m_glt = 0;
    @(negedge clk_i);
    start_i = 1'b1; erase_i = 1'b0; toggle_i = 1'b0; limit_i = 16'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R10", "busy after reset", int'(busy_o), 0);
    check("R10", "req after reset", int'(rd_req_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R10", "stays idle", int'(busy_o | done_o | err_timeout_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule